// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This peripheral drives two independent pulse outputs. Software sets each one through a small 32-bit register bus. Each channel picks one of four source clock strobes and divides it by an integer. A gate then passes or stops the result. The gated ticks step a counter. The counter holds the output high for a programmed number of ticks, then low for a second programmed number, and repeats.

A waveform is described by its two phase lengths, not by a period and a compare value. The low phase always lasts at least one tick, so an enabled output is never high for a whole period. Polarity inversion is left to software, which swaps the two lengths. Each source clock arrives as a single-cycle enable strobe in the system clock domain.

Top module: `hilo_pwm`

## Requirements
- R1: The register map decodes three word addresses. Address 0x0 is channel A's length register and 0x4 is channel B's: bits 31:16 hold the high length and bits 15:0 the low length. Address 0x8 is the control register. Its fields are: enable bit 0 (A) and bit 1 (B); source select bits 5:4 (A) and 7:6 (B); divider bits 14:8 (A) and 22:16 (B); gate bit 15 (A) and bit 23 (B). Reads return the stored values, and control bits outside these fields read 0. After reset every register reads 0 and both outputs are low.
- R2: In each period an enabled, gated channel drives its output high for H ticks, then low for L ticks.
- R3: A high length of 0 keeps the output low for the whole period.
- R4: A low length of 0 still gives one low tick per period.
- R5: With divider value D, the channel takes one tick for every D+1 strobes of its selected source. D = 0 passes every strobe.
- R6: Select value s (0 to 3) makes the channel count strobes of source input s only.
- R7: Clearing a channel's enable bit drives its output low in the cycle after the write's clock edge, whatever phase it is in.
- R8: Setting the enable bit starts a period in the high phase. The output rises after the clock edge that follows the write edge, when H is nonzero.
- R9: A write to a length register does not change the period in progress. The new lengths take effect at the next period boundary.
- R10: While a channel's gate bit is clear, its counter stops and its output holds its level. Setting the gate again resumes the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_stb | input | 4 | One enable strobe per source clock |
| pwm_out | output | 2 | Channel outputs, bit 0 = A, bit 1 = B |

## Verification
On every cycle the assertions check these invariants: the phase counter stays inside the latched high or low length; a zero high length never produces a high phase; a new period starts high; latched lengths change only at a period boundary; the counter and phase do not move on a cycle without a tick; a cleared enable stops the channel. Run lengths in cycles depend on the divider, the select and the lengths together, so only the bench can show them. It sweeps divider, high and low values, sweeps every source, and times the immediate stop, the start, the boundary-aligned update and the gate hold at the ports.

// File: rtl/hilo_pwm_pkg.sv
package hilo_pwm_pkg;

  localparam int CNT_W  = 16;
  localparam int DIV_W  = 7;
  localparam int NSRC   = 4;
  localparam int SEL_W  = $clog2(NSRC);
  localparam int NCHAN  = 2;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  // Channel ch fields: enable bit ch, select at 4+2ch, divider at 8+8ch, gate at 15+8ch
  function automatic chan_cfg_t cfg_of(input logic [31:0] ctrl, input int ch);
    chan_cfg_t c;
    c.en   = ctrl[ch];
    c.sel  = ctrl[4 + SEL_W*ch +: SEL_W];
    c.div  = ctrl[8 + 8*ch +: DIV_W];
    c.gate = ctrl[15 + 8*ch];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_mask();
    logic [31:0] m = '0;
    for (int ch = 0; ch < NCHAN; ch++) begin
      m[ch] = 1'b1;
      m[4 + SEL_W*ch +: SEL_W] = '1;
      m[8 + 8*ch +: DIV_W] = '1;
      m[15 + 8*ch] = 1'b1;
    end
    return m;
  endfunction

  // The low phase never lasts fewer than one tick
  function automatic logic [CNT_W-1:0] low_span(input logic [CNT_W-1:0] lo);
    return (lo == '0) ? CNT_W'(1) : lo;
  endfunction

endpackage

// File: rtl/hilo_pwm_regs.sv
module hilo_pwm_regs
  import hilo_pwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wen,
  input  logic [3:0]            addr,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [NCHAN-1:0][31:0] len_q,
  output logic [31:0]           ctrl_q
);

  localparam logic [31:0] MASK = ctrl_mask();
  localparam logic [3:0]  CTRL_ADDR = 4'(4 * NCHAN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      ctrl_q <= '0;
    end else if (wen) begin
      for (int ch = 0; ch < NCHAN; ch++)
        if (addr == 4'(4 * ch)) len_q[ch] <= wdata;
      if (addr == CTRL_ADDR) ctrl_q <= wdata & MASK;
    end
  end

  always_comb begin
    rdata = '0;
    for (int ch = 0; ch < NCHAN; ch++)
      if (addr == 4'(4 * ch)) rdata = len_q[ch];
    if (addr == CTRL_ADDR) rdata = ctrl_q;
  end

endmodule

// File: rtl/hilo_pwm_tick.sv
module hilo_pwm_tick #(
  parameter int NSRC  = 4,
  parameter int DIV_W = 7,
  localparam int SEL_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_stb,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic             gate,
  output logic             tick
);

  logic [DIV_W-1:0] div_cnt;
  logic             sel_stb;
  logic             div_wrap;

  assign sel_stb  = src_stb[sel];
  assign div_wrap = sel_stb && (div_cnt >= div);
  assign tick     = div_wrap && gate;

  always_ff @(posedge clk) begin
    if (!rst_n)        div_cnt <= '0;
    else if (div_wrap) div_cnt <= '0;
    else if (sel_stb)  div_cnt <= div_cnt + 1'b1;
  end

  p_div_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_wrap |=> (div_cnt == '0));

  p_div_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_stb[sel] |=> $stable(div_cnt));

endmodule

// File: rtl/hilo_pwm_phase.sv
module hilo_pwm_phase
  import hilo_pwm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic         pwm_out
);

  logic         running;
  logic         phase_hi;
  logic [W-1:0] cnt;
  logic [W-1:0] hi_q, lo_q;
  logic         high_end;
  logic         period_end;

  assign high_end   = running && tick && phase_hi && (cnt == hi_q - W'(1));
  assign period_end = running && tick && !phase_hi && (cnt == low_span(lo_q) - W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (!en) begin
      running  <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (!running || period_end) begin
      running  <= 1'b1;
      hi_q     <= hi_in;
      lo_q     <= lo_in;
      phase_hi <= (hi_in != '0);
      cnt      <= '0;
    end else if (high_end) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (tick) begin
      cnt <= cnt + W'(1);
    end
  end

  assign pwm_out = en && running && phase_hi;

  p_high_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && phase_hi) |-> (cnt < hi_q));

  p_low_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !phase_hi) |-> (cnt < low_span(lo_q)));

  p_zero_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && hi_q == '0) |-> !phase_hi);

  p_start_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> (phase_hi == (hi_q != '0)));

  p_latch_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$stable(hi_q)) |-> $past(period_end));

  p_gate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && running && !tick) |=> ($stable(cnt) && $stable(phase_hi)));

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !running);

endmodule

// File: rtl/hilo_pwm.sv
module hilo_pwm
  import hilo_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wen,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  src_stb,
  output logic [1:0]  pwm_out
);

  logic [NCHAN-1:0][31:0] len_q;
  logic [31:0]            ctrl_q;

  hilo_pwm_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wen   (bus_wen),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .len_q (len_q),
    .ctrl_q(ctrl_q)
  );

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    chan_cfg_t cfg;
    logic      tick;

    assign cfg = cfg_of(ctrl_q, ch);

    hilo_pwm_tick #(.NSRC(NSRC), .DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_stb(src_stb),
      .sel    (cfg.sel),
      .div    (cfg.div),
      .gate   (cfg.gate),
      .tick   (tick)
    );

    hilo_pwm_phase #(.W(CNT_W)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg.en),
      .tick   (tick),
      .hi_in  (len_q[ch][31:16]),
      .lo_in  (len_q[ch][15:0]),
      .pwm_out(pwm_out[ch])
    );
  end

endmodule

// File: tb/hilo_pwm_bench.sv
`timescale 1ns/1ps
module hilo_pwm_bench;

  localparam int LIMIT = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_stb;
  logic [1:0]  pwm_out;
  int          scnt = 0;
  int          nchk = 0;
  int          nerr = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  hilo_pwm u_hilo_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wen  (bus_wen),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_stb  (src_stb),
    .pwm_out  (pwm_out)
  );

  always #2 clk = ~clk;

  // source i strobes once every i+1 cycles
  always @(negedge clk) scnt <= scnt + 1;
  always_comb
    for (int i = 0; i < 4; i++) src_stb[i] = ((scnt % (i + 1)) == 0);

  function automatic int run_len(int n, int d, int s);
    return n * (d + 1) * (s + 1);
  endfunction

  function automatic logic [31:0] ctl(int ch, bit en, bit gate, int sel, int div);
    logic [31:0] v = '0;
    v[ch] = en;
    v[4 + 2*ch +: 2] = 2'(sel);
    v[8 + 8*ch +: 7] = 7'(div);
    v[15 + 8*ch] = gate;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_lvl(int ch, bit lvl, output int n);
    n = 0;
    while (pwm_out[ch] != lvl && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic measure(int ch, output int lo_run, output int hi_run);
    int dummy;
    wait_lvl(ch, 1'b1, dummy);
    wait_lvl(ch, 1'b0, dummy);
    wait_lvl(ch, 1'b1, lo_run);
    wait_lvl(ch, 1'b0, hi_run);
  endtask

  task automatic count_high(int ch, int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++; nchk++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    int lo_run, hi_run, n, dummy;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and readback
    rd(4'h0, v); chk("R1 reset len A", int'(v), 0);
    rd(4'h4, v); chk("R1 reset len B", int'(v), 0);
    rd(4'h8, v); chk("R1 reset ctrl", int'(v), 0);
    chk("R1 reset outputs", int'(pwm_out), 0);
    wr(4'h0, 32'h1234_5678); wr(4'h4, 32'h0abc_4ef0); wr(4'h8, 32'hffff_ffff);
    rd(4'h0, v); chk("R1 len A readback", int'(v), 32'h1234_5678);
    rd(4'h4, v); chk("R1 len B readback", int'(v), 32'h0abc_4ef0);
    rd(4'h8, v); chk("R1 ctrl readback", int'(v), 32'h00ff_fff3);
    rd(4'hc, v); chk("R1 unmapped read", int'(v), 0);
    wr(4'h8, 32'h0);

    // R2 R3 R4 R5 sweep on channel A, source 0
    for (int d = 0; d < 3; d++)
      for (int h = 0; h < 4; h++)
        for (int l = 0; l < 4; l++) begin
          wr(4'h8, 32'h0);
          wr(4'h0, {16'(h), 16'(l)});
          wr(4'h8, ctl(0, 1, 1, 0, d));
          if (h == 0) begin
            count_high(0, 60, n);
            chk("R3 zero high stays low", n, 0);
          end else begin
            measure(0, lo_run, hi_run);
            chk("R2 R5 high run", hi_run, run_len(h, d, 0));
            chk(l == 0 ? "R4 minimum low run" : "R2 R5 low run",
                lo_run, run_len(l == 0 ? 1 : l, d, 0));
          end
        end
    wr(4'h8, 32'h0);

    // R6 source select sweep on channel B, divider 1, H=2 L=1
    wr(4'h4, {16'd2, 16'd1});
    for (int s = 0; s < 4; s++) begin
      wr(4'h8, 32'h0);
      wr(4'h8, ctl(1, 1, 1, s, 1));
      measure(1, lo_run, hi_run);
      chk("R6 select high run", hi_run, run_len(2, 1, s));
      chk("R6 select low run", lo_run, run_len(1, 1, s));
      chk("R6 channel A idle", int'(pwm_out[0]), 0);
    end
    wr(4'h8, 32'h0);

    // R8 start in high phase
    wr(4'h0, {16'd3, 16'd2});
    wr(4'h8, ctl(0, 1, 1, 0, 0));
    chk("R8 not yet high after write edge", int'(pwm_out[0]), 0);
    @(negedge clk);
    chk("R8 high one edge later", int'(pwm_out[0]), 1);

    // R7 immediate stop mid high phase
    wr(4'h8, 32'h0);
    wr(4'h0, {16'd200, 16'd2});
    wr(4'h8, ctl(0, 1, 1, 0, 0));
    repeat (3) @(negedge clk);
    chk("R7 high before stop", int'(pwm_out[0]), 1);
    wr(4'h8, 32'h0);
    chk("R7 low right after stop", int'(pwm_out[0]), 0);
    count_high(0, 20, n);
    chk("R7 stays low", n, 0);

    // R9 new lengths at boundary
    wr(4'h0, {16'd2, 16'd2});
    wr(4'h8, ctl(0, 1, 1, 0, 0));
    wait_lvl(0, 1'b1, dummy);
    wait_lvl(0, 1'b0, dummy);
    wait_lvl(0, 1'b1, dummy);
    wr(4'h0, {16'd5, 16'd2});
    chk("R9 current high keeps old length", int'(pwm_out[0]), 0);
    wait_lvl(0, 1'b1, lo_run);
    wait_lvl(0, 1'b0, hi_run);
    chk("R9 low run of current period", lo_run, 2);
    chk("R9 next high uses new length", hi_run, 5);
    wr(4'h8, 32'h0);

    // R10 gate hold, high then low
    wr(4'h0, {16'd3, 16'd3});
    wr(4'h8, ctl(0, 1, 1, 0, 3));
    wait_lvl(0, 1'b1, dummy);
    wr(4'h8, ctl(0, 1, 0, 0, 3));
    count_high(0, 40, n);
    chk("R10 high held while gated", n, 40);
    wr(4'h8, ctl(0, 1, 1, 0, 3));
    wait_lvl(0, 1'b0, n);
    chk("R10 resumes and falls", int'(n < 20), 1);
    wr(4'h8, ctl(0, 1, 0, 0, 3));
    count_high(0, 40, n);
    chk("R10 low held while gated", n, 0);
    wr(4'h8, ctl(0, 1, 1, 0, 3));
    wait_lvl(0, 1'b1, n);
    chk("R10 resumes and rises", int'(n < 20), 1);
    wr(4'h8, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule